// File: doc/BRIEF.md
# Composite Key-On Controller for a Six-Channel FM Voice Array

This block drives the key-on levels of an FM synthesis core that has six channels with four operator slots each. It watches a byte-wide register write bus and two of its registers. One register holds a two-bit operating mode for the third channel. The other carries manual key commands: a channel code plus one key flag per slot. Each slot's level is the state the envelope generators downstream follow.

In composite mode, the third channel is also keyed by a timer. Each enabled overflow of an external timer produces a one-cycle key-on of all four of that channel's slots, and the slots key off again on the next cycle. A manual key-on held on the third channel stops these automatic pairs. They start again once the manual flags for that channel are written back to zero. The timer, the envelope generators and the audio path are not part of this block.

Top module: `fm_keyon_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all 24 key levels are 0. No manual hold remains after reset, so an overflow in composite mode fires straight away.
- R2: A write with bank_sel 0 to address 0x28 loads data bits 7:4 into the levels of the selected channel. Data bit 4 drives slot 0 and bit 7 drives slot 3, and the four bits may take any pattern. Level bit ch*4+slot is the output, with channel index 0 to 5. The new value shows from the clock edge that samples the write.
- R3: Channel code data[2:0] values 0, 1 and 2 select indices 0, 1 and 2. Values 4, 5 and 6 select indices 3, 4 and 5. Values 3 and 7 change no level.
- R4: Writes with bank_sel 1 change neither a key level nor the mode.
- R5: The mode is data bits 7:6 of a bank-0 write to address 0x27, and value 2'b10 is composite. In composite mode, an overflow sampled with the timer enable high drives all four level bits of channel index 2 high for exactly one cycle, starting at the edge that samples the overflow. On the next cycle those bits return to their manual value. Overflows on consecutive cycles keep the bits high for each of those cycles.
- R6: In modes 2'b00, 2'b01 and 2'b11 an overflow has no effect. Mode 2'b11 acts exactly like 2'b01.
- R7: An overflow sampled while the timer enable is low has no effect.
- R8: While channel index 2 holds any nonzero manual flags, overflows fire no automatic pulse. After a manual write of all-zero flags to that channel, pulses fire again.
- R9: The suppression test uses the manual flags held before the sampling edge. An overflow sampled together with a manual key-on to channel index 2 still gives one cycle of all four bits high, and then the manual pattern shows.
- R10: Mode writes, key writes and overflows may arrive in any mix on any cycle, and the levels follow R2 to R9 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| bank_sel | input | 1 | Register bank of the write; only 0 is decoded |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_en | input | 1 | Timer running enable; gates the overflow |
| key_lvl | output | 24 | Key-on level per slot, bit ch*4+slot |

## Verification
Every result of this block is due at the first clock edge that samples its cause. A key write, a mode write and an overflow each show in key_lvl during the cycle that follows that edge. The automatic pulse also clears one edge later. The bench drives each stimulus just after a falling edge and updates its reference model as that rising edge will. It then compares key_lvl at the next falling edge, so each comparison sits exactly one register stage after its cause. The directed cases cover the pulse's single-cycle width, back-to-back overflows, and a key-on sampled on the same edge as an overflow. Seeded random traffic then mixes all the inputs.

// File: rtl/fm_kc_pkg.sv
`timescale 1ns/1ps
package fm_kc_pkg;

   typedef enum logic [1:0] {
      CH3_NORMAL        = 2'b00,
      CH3_SPECIAL       = 2'b01,
      CH3_COMPOSITE     = 2'b10,
      CH3_SPECIAL_ALIAS = 2'b11
   } ch3_mode_e;

   // Only one encoding arms the timer-driven keying; the two special
   // encodings differ only in frequency handling outside this block.
   function automatic logic mode_is_composite(input ch3_mode_e m);
      return m == CH3_COMPOSITE;
   endfunction

endpackage

// File: rtl/fm_kc_regdec.sv
`timescale 1ns/1ps
module fm_kc_regdec
   import fm_kc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MODE_ADDR  = 'h27,
   parameter int unsigned KEY_ADDR   = 'h28,
   parameter int unsigned MODE_LSB   = 6,
   parameter int unsigned KEY_LSB    = 4,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned CH_PER_GRP = 3,
   parameter int unsigned NUM_CH     = 6,
   parameter int unsigned NUM_SLOT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              bank_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output ch3_mode_e         mode_q,
   output logic [NUM_CH-1:0] chan_hit,
   output logic [NUM_SLOT-1:0] key_flags
);

   localparam int unsigned GRP_W = $clog2(CH_PER_GRP);

   logic              glob_wr;
   logic              mode_wr;
   logic              key_wr;
   logic [CODE_W-1:0] chan_code;
   logic              data_unused;

   assign glob_wr   = wr_en & ~bank_sel;
   assign mode_wr   = glob_wr && (wr_addr == ADDR_W'(MODE_ADDR));
   assign key_wr    = glob_wr && (wr_addr == ADDR_W'(KEY_ADDR));
   assign chan_code = wr_data[CODE_W-1:0];
   assign key_flags = wr_data[KEY_LSB +: NUM_SLOT];
   assign data_unused = ^wr_data;

   // Each channel owns one code: group number above the sub-field,
   // position within the group below it. Unused sub-codes match nothing.
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
      localparam int unsigned CODE_VAL =
         ((ch / CH_PER_GRP) << GRP_W) | (ch % CH_PER_GRP);
      assign chan_hit[ch] = key_wr && (chan_code == CODE_W'(CODE_VAL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CH3_NORMAL;
      end else if (mode_wr) begin
         mode_q <= ch3_mode_e'(wr_data[MODE_LSB +: 2]);
      end
   end

endmodule

// File: rtl/fm_kc_slot_bank.sv
`timescale 1ns/1ps
module fm_kc_slot_bank #(
   parameter int unsigned NUM_CH   = 6,
   parameter int unsigned NUM_SLOT = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0]            chan_hit,
   input  logic [NUM_SLOT-1:0]          key_flags,
   output logic [NUM_CH*NUM_SLOT-1:0]   man_lvl
);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [NUM_SLOT-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= '0;
         end else if (chan_hit[ch]) begin
            lvl_q <= key_flags;
         end
      end
      assign man_lvl[ch*NUM_SLOT +: NUM_SLOT] = lvl_q;
   end

endmodule

// File: rtl/fm_kc_auto_gen.sv
`timescale 1ns/1ps
module fm_kc_auto_gen
   import fm_kc_pkg::*;
#(
   parameter int unsigned NUM_SLOT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tmr_ovf,
   input  logic                tmr_en,
   input  ch3_mode_e           mode,
   input  logic [NUM_SLOT-1:0] owner_lvl,
   output logic                auto_pulse
);

   logic fire;

   // A held manual key on the timed channel is the override state itself.
   assign fire = tmr_ovf & tmr_en & mode_is_composite(mode) & ~(|owner_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_pulse <= 1'b0;
      end else begin
         auto_pulse <= fire;
      end
   end

endmodule

// File: rtl/fm_keyon_ctrl.sv
`timescale 1ns/1ps
module fm_keyon_ctrl
   import fm_kc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MODE_ADDR  = 'h27,
   parameter int unsigned KEY_ADDR   = 'h28,
   parameter int unsigned MODE_LSB   = 6,
   parameter int unsigned KEY_LSB    = 4,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned CH_PER_GRP = 3,
   parameter int unsigned NUM_CH     = 6,
   parameter int unsigned NUM_SLOT   = 4,
   parameter int unsigned AUTO_CH    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       bank_sel,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       tmr_ovf,
   input  logic                       tmr_en,
   output logic [NUM_CH*NUM_SLOT-1:0] key_lvl
);

   localparam int unsigned GRP_W   = $clog2(CH_PER_GRP);
   localparam int unsigned MAX_CH  = (1 << (CODE_W - GRP_W)) * CH_PER_GRP;

   if (AUTO_CH >= NUM_CH) begin : g_bad_auto
      $error("timed channel index outside the channel range");
   end
   if (NUM_CH > MAX_CH) begin : g_bad_code
      $error("channel code too narrow for the channel count");
   end
   if (KEY_LSB + NUM_SLOT > DATA_W || MODE_LSB + 2 > DATA_W) begin : g_bad_field
      $error("register field beyond the data width");
   end
   if (KEY_LSB < CODE_W) begin : g_bad_overlap
      $error("key flags overlap the channel code");
   end

   ch3_mode_e                  mode_q;
   logic [NUM_CH-1:0]          chan_hit;
   logic [NUM_SLOT-1:0]        key_flags;
   logic [NUM_CH*NUM_SLOT-1:0] man_lvl;
   logic [NUM_SLOT-1:0]        ch3_manual;
   logic                       auto_pulse;

   fm_kc_regdec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR),
      .MODE_LSB(MODE_LSB), .KEY_LSB(KEY_LSB),
      .CODE_W(CODE_W), .CH_PER_GRP(CH_PER_GRP),
      .NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .mode_q(mode_q), .chan_hit(chan_hit), .key_flags(key_flags)
   );

   fm_kc_slot_bank #(
      .NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .chan_hit(chan_hit),
      .key_flags(key_flags), .man_lvl(man_lvl)
   );

   assign ch3_manual = man_lvl[AUTO_CH*NUM_SLOT +: NUM_SLOT];

   fm_kc_auto_gen #(
      .NUM_SLOT(NUM_SLOT)
   ) u_auto (
      .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .tmr_en(tmr_en),
      .mode(mode_q), .owner_lvl(ch3_manual), .auto_pulse(auto_pulse)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
      if (ch == AUTO_CH) begin : g_timed
         assign key_lvl[ch*NUM_SLOT +: NUM_SLOT] =
            man_lvl[ch*NUM_SLOT +: NUM_SLOT] | {NUM_SLOT{auto_pulse}};
      end else begin : g_plain
         assign key_lvl[ch*NUM_SLOT +: NUM_SLOT] = man_lvl[ch*NUM_SLOT +: NUM_SLOT];
      end
   end

endmodule

// File: rtl/fm_kc_chk.sv
`timescale 1ns/1ps
module fm_kc_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MODE_ADDR = 'h27,
   parameter int unsigned KEY_ADDR  = 'h28,
   parameter int unsigned NUM_CH    = 6,
   parameter int unsigned NUM_SLOT  = 4,
   parameter int unsigned AUTO_CH   = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic                       bank_sel,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       tmr_ovf,
   input logic                       tmr_en,
   input logic [NUM_CH*NUM_SLOT-1:0] key_lvl,
   input logic [1:0]                 mode_q,
   input logic [NUM_SLOT-1:0]        ch3_manual,
   input logic                       auto_pulse
);

   localparam int unsigned W = NUM_CH * NUM_SLOT;
   localparam logic [W-1:0] AUTO_MASK = W'({NUM_SLOT{1'b1}}) << (AUTO_CH * NUM_SLOT);

   logic key_wr_g;
   logic mode_wr_g;
   assign key_wr_g  = wr_en && !bank_sel && (wr_addr == ADDR_W'(KEY_ADDR));
   assign mode_wr_g = wr_en && !bank_sel && (wr_addr == ADDR_W'(MODE_ADDR));

   // R5: a pulse only follows an overflow sampled in composite mode
   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pulse |-> $past(tmr_ovf && mode_q == 2'b10));

   // R7: the timer enable gates every pulse
   p_pulse_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pulse |-> $past(tmr_en));

   // R8: a held manual key on the timed channel blocks pulses
   p_pulse_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pulse |-> $past(ch3_manual) == '0);

   // R4: untimed levels move only after a bank-0 key write
   p_plain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((key_lvl & ~AUTO_MASK) != ($past(key_lvl) & ~AUTO_MASK)) |-> $past(key_wr_g));

   // R4: mode only changes after a bank-0 mode write
   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_wr_g) |-> $stable(mode_q));

   // R3: unused channel codes leave every untimed level alone
   p_code_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(key_wr_g && wr_data[1:0] == 2'b11) |->
         ((key_lvl & ~AUTO_MASK) == ($past(key_lvl) & ~AUTO_MASK)));

endmodule

bind fm_keyon_ctrl fm_kc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR),
   .NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .AUTO_CH(AUTO_CH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
   .wr_addr(wr_addr), .wr_data(wr_data), .tmr_ovf(tmr_ovf), .tmr_en(tmr_en),
   .key_lvl(key_lvl), .mode_q(mode_q), .ch3_manual(ch3_manual),
   .auto_pulse(auto_pulse)
);

// File: tb/sim_fm_keyon_ctrl.sv
`timescale 1ns/1ps
module sim_fm_keyon_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, bank_sel, tmr_ovf, tmr_en;
   logic [7:0]  wr_addr, wr_data;
   logic [23:0] key_lvl;

   always #10 clk = ~clk;

   fm_keyon_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .tmr_ovf(tmr_ovf),
      .tmr_en(tmr_en), .key_lvl(key_lvl)
   );

   int         n_chk = 0;
   int         n_bad = 0;
   logic [1:0] m_mode;
   logic [3:0] m_man [6];
   logic       m_pulse;

   function automatic logic [23:0] exp_out();
      logic [23:0] v = '0;
      for (int c = 0; c < 6; c++) v[c*4 +: 4] = m_man[c];
      if (m_pulse) v[11:8] = 4'hF;
      return v;
   endfunction

   task automatic check(input string tag);
      logic [23:0] e = exp_out();
      n_chk++;
      if (key_lvl !== e) begin
         n_bad++;
         $display("FAIL %s: key_lvl=%06h expected %06h", tag, key_lvl, e);
      end
   endtask

   task automatic model_reset();
      m_mode = 2'b00; m_pulse = 1'b0;
      for (int c = 0; c < 6; c++) m_man[c] = 4'h0;
   endtask

   // Drive one cycle of inputs, advance the model as the edge will, check.
   task automatic step(input logic we, input logic bk, input logic [7:0] a,
                       input logic [7:0] d, input logic ov, input logic en,
                       input string tag);
      logic nxt;
      wr_en = we; bank_sel = bk; wr_addr = a; wr_data = d;
      tmr_ovf = ov; tmr_en = en;
      nxt = ov && en && (m_mode == 2'b10) && (m_man[2] == 4'h0);
      if (we && !bk) begin
         if (a == 8'h27) m_mode = d[7:6];
         if (a == 8'h28 && d[1:0] != 2'b11)
            m_man[d[2] ? 3 + int'(d[1:0]) : int'(d[1:0])] = d[7:4];
      end
      m_pulse = nxt;
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      rst_n = 1'b0; wr_en = 0; bank_sel = 0; wr_addr = 0; wr_data = 0;
      tmr_ovf = 0; tmr_en = 0;
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 during reset");
      rst_n = 1'b1;
      idle("R1 after release");

      // R1 + R5: no hold after reset, pulse one cycle wide
      step(1, 0, 8'h27, 8'h80, 0, 1, "R5 mode write");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R1 R5 pulse high");
      idle("R5 pulse cleared");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R5 back-to-back first");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R5 back-to-back second");
      idle("R5 back-to-back end");

      // R2: individual patterns
      step(1, 0, 8'h28, 8'h51, 0, 1, "R2 chan index1 0101");
      step(1, 0, 8'h28, 8'hA4, 0, 1, "R2 chan index3 1010");
      step(1, 0, 8'h28, 8'h80, 0, 1, "R2 chan index0 slot3");
      // R3
      step(1, 0, 8'h28, 8'hF3, 0, 1, "R3 code3 ignored");
      step(1, 0, 8'h28, 8'hF7, 0, 1, "R3 code7 ignored");
      step(1, 0, 8'h28, 8'h36, 0, 1, "R3 code6 to index5");
      step(1, 0, 8'h28, 8'hC5, 0, 1, "R3 code5 to index4");
      // R4
      step(1, 1, 8'h28, 8'hF0, 0, 1, "R4 bank1 key write");
      step(1, 1, 8'h27, 8'h00, 0, 1, "R4 bank1 mode write");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R4 mode kept composite");
      idle("R4 settle");
      // R7
      step(0, 0, 8'h00, 8'h00, 1, 0, "R7 enable low");
      // R6
      step(1, 0, 8'h27, 8'h40, 0, 1, "R6 mode 01");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R6 mode 01 overflow");
      step(1, 0, 8'h27, 8'hC0, 0, 1, "R6 mode 11");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R6 mode 11 overflow");
      step(1, 0, 8'h27, 8'h00, 0, 1, "R6 mode 00");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R6 mode 00 overflow");
      step(1, 0, 8'h27, 8'h80, 0, 1, "R6 back to composite");
      // R8
      step(1, 0, 8'h28, 8'h32, 0, 1, "R8 manual on");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R8 overflow suppressed");
      step(1, 0, 8'h28, 8'h02, 0, 1, "R8 manual off");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R8 pulse resumes");
      idle("R8 settle");
      // R9
      step(1, 0, 8'h28, 8'h12, 1, 1, "R9 same-edge pulse");
      idle("R9 manual shows");
      step(0, 0, 8'h00, 8'h00, 1, 1, "R9 held blocks");
      step(1, 0, 8'h28, 8'h02, 0, 1, "R9 release");

      // R10: seeded random mix
      for (int i = 0; i < 3000; i++) begin
         logic       we, bk, ov, en;
         logic [7:0] a, d;
         int unsigned r = $urandom % 10;
         we = ($urandom % 10) < 4;
         bk = ($urandom % 10) == 0;
         a  = (r < 4) ? 8'h28 : (r < 6) ? 8'h27 : 8'($urandom);
         d  = 8'($urandom);
         if (($urandom % 4) == 0) d[7:4] = 4'h0;
         ov = ($urandom % 10) < 3;
         en = ($urandom % 10) < 8;
         step(we, bk, a, d, ov, en, "R10 random mix");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule